// File: doc/BRIEF.md
# RDMA Command Segmentation Engine

The engine lets software start a remote copy by filling four argument slots of a command line. The slots are transfer size, source address, destination address and acknowledgment address. No separate start bit exists. The transfer begins on its own once every slot has been filled. The engine then sends the transfer as a series of write packets. Each packet carries at most 64 bytes, and its source and destination addresses move forward by the bytes already sent.

The same engine serves packets that arrive at the local scratchpad:

- A read request is answered with write replies. The replies are cut into packets in the same way, aimed at the read's destination, and tagged with its acknowledgment address.
- A write is answered with one acknowledgment. The acknowledgment carries the write's byte count, so a remote counter can add it up.
- An arriving acknowledgment is absorbed and produces no packet.

All outgoing packets share one valid/ready port.

Top module: `rdma_cmd_engine`

## Requirements
- R1: A command starts only after all four argument slots are written. The slot selector codes are 0 size, 1 source, 2 destination, 3 acknowledgment. With any slot still empty, no packet is produced.
- R2: Writing a slot again before launch replaces its value and does not start the transfer. The launched command uses the most recent value.
- R3: A transfer of N bytes is sent as packets of 64 bytes each, except the last, which carries the remainder of 1 to 64 bytes. The count is ceil(N/64).
- R4: Each packet's source and destination equal the command's start addresses plus the bytes already sent. Every packet carries the command's acknowledgment address.
- R5: The packet type field is 2 bits: 00 read, 01 write, 10 acknowledgment. Data packets from commands and read replies are type 01, and the engine never emits type 00.
- R6: An accepted incoming read (type 00) produces write packets to the read's destination, with its acknowledgment address. They are segmented as in R3 and R4, starting from the read's source.
- R7: An accepted incoming write (type 01) produces exactly one type-10 packet. It goes to the write's acknowledgment address, its size field is the write's byte count, and its source and acknowledgment fields are zero.
- R8: An accepted incoming acknowledgment (type 10) produces no packet.
- R9: While outValid is high and outReady is low, outValid stays high and every packet field holds its value.
- R10: The written-slot set clears when a command launches. Slot writes made while a transfer is in flight are kept for the next command, which then launches on its own.
- R11: A command or read of size zero is consumed and emits no packet.
- R12: inReady is low while any packet is being sent, and also while a complete command waits to launch.
- R13: After reset, outValid is low, inReady is high, and no slot counts as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Argument slot write strobe |
| cmdWrSel | input | 2 | Slot select: 0 size, 1 source, 2 destination, 3 acknowledgment |
| cmdWrData | input | ADDR_W | Slot value (size uses the low SIZE_W bits) |
| inValid | input | 1 | Incoming packet present |
| inReady | output | 1 | Incoming packet accepted this cycle when inValid is high |
| inType | input | 2 | Incoming packet type |
| inSize | input | SIZE_W | Incoming byte count |
| inSrc | input | ADDR_W | Incoming source address |
| inDst | input | ADDR_W | Incoming destination address |
| inAck | input | ADDR_W | Incoming acknowledgment address |
| outValid | output | 1 | Outgoing packet present |
| outReady | input | 1 | Network takes the outgoing packet |
| outType | output | 2 | Outgoing packet type |
| outSize | output | SIZE_W | Segment byte count, or acknowledged byte count |
| outSrc | output | ADDR_W | Outgoing source address |
| outDst | output | ADDR_W | Outgoing destination address |
| outAck | output | ADDR_W | Outgoing acknowledgment address |

## Verification
Some properties are checked by the assertions on every cycle:
- the hold rule on a stalled output;
- the bound of 1 to 64 bytes on write segments;
- the ban on emitted read packets;
- the exclusion between inReady and a pending output.

Other behaviour can only be shown by the bench's scenarios. This covers the slot-fill launch and its overwrite rule, the exact segment sizes and address steps, the shape of the read replies and acknowledgments, zero-size commands, and the hand-over of arguments written during a busy transfer.

// File: rtl/rdma_eng_pkg.sv
package rdma_eng_pkg;

  typedef enum logic [1:0] {
    PKT_READ  = 2'b00,
    PKT_WRITE = 2'b01,
    PKT_ACK   = 2'b10
  } pkt_type_e;

  typedef enum logic [1:0] {
    ARG_SIZE = 2'd0,
    ARG_SRC  = 2'd1,
    ARG_DST  = 2'd2,
    ARG_ACK  = 2'd3
  } arg_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldCmd;    // copy argument slots into the working registers
    logic ldRead;   // copy an incoming read into the working registers
    logic ldAck;    // build an acknowledgment from an incoming write
    logic advance;  // a segment was taken, step to the next one
  } eng_ctl_t;

endpackage

// File: rtl/rdma_eng_ctrl.sv
module rdma_eng_ctrl
  import rdma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrEn,
  input  logic [1:0] cmdWrSel,
  input  logic       inValid,
  input  logic [1:0] inType,
  input  logic       inSizeZero,
  input  logic       cmdSizeZero,
  input  logic       lastSeg,
  input  logic       outReady,
  output eng_ctl_t   ctl,
  output logic       outValid,
  output logic       inReady
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_ACKOUT} state_e;

  state_e     state, nextState;
  logic [3:0] argMask;
  logic       maskFull;
  logic       launch;

  assign maskFull = (argMask == 4'hF);
  assign inReady  = (state == ST_IDLE) && !maskFull;

  always_comb begin
    ctl       = '0;
    nextState = state;
    outValid  = 1'b0;
    launch    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (maskFull) begin
          launch    = 1'b1;
          ctl.ldCmd = 1'b1;
          if (!cmdSizeZero) nextState = ST_SEG;
        end else if (inValid) begin
          unique case (pkt_type_e'(inType))
            PKT_READ: begin
              ctl.ldRead = 1'b1;
              if (!inSizeZero) nextState = ST_SEG;
            end
            PKT_WRITE: begin
              ctl.ldAck = 1'b1;
              nextState = ST_ACKOUT;
            end
            default: ;  // acknowledgments and unused codes are absorbed
          endcase
        end
      end
      ST_SEG: begin
        outValid = 1'b1;
        if (outReady) begin
          ctl.advance = 1'b1;
          if (lastSeg) nextState = ST_IDLE;
        end
      end
      ST_ACKOUT: begin
        outValid = 1'b1;
        if (outReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      argMask <= '0;
    end else begin
      state   <= nextState;
      argMask <= (launch ? 4'h0 : argMask) | (cmdWrEn ? (4'b0001 << cmdWrSel) : 4'h0);
    end
  end

endmodule

// File: rtl/rdma_eng_dp.sv
module rdma_eng_dp
  import rdma_eng_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 16,
  parameter int MAX_PKT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  eng_ctl_t          ctl,
  input  logic              cmdWrEn,
  input  logic [1:0]        cmdWrSel,
  input  logic [ADDR_W-1:0] cmdWrData,
  input  logic [SIZE_W-1:0] inSize,
  input  logic [ADDR_W-1:0] inSrc,
  input  logic [ADDR_W-1:0] inDst,
  input  logic [ADDR_W-1:0] inAck,
  output logic              cmdSizeZero,
  output logic              lastSeg,
  output logic [1:0]        outType,
  output logic [SIZE_W-1:0] outSize,
  output logic [ADDR_W-1:0] outSrc,
  output logic [ADDR_W-1:0] outDst,
  output logic [ADDR_W-1:0] outAck
);

  localparam logic [SIZE_W-1:0] MaxSz = SIZE_W'(MAX_PKT);

  logic [SIZE_W-1:0] argSize, wSize, segSize;
  logic [ADDR_W-1:0] argSrc, argDst, argAck;
  logic [ADDR_W-1:0] wSrc, wDst, wAck;
  pkt_type_e         wType;

  assign cmdSizeZero = (argSize == '0);
  assign lastSeg     = (wSize <= MaxSz);
  assign segSize     = lastSeg ? wSize : MaxSz;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argSize <= '0;
      argSrc  <= '0;
      argDst  <= '0;
      argAck  <= '0;
    end else if (cmdWrEn) begin
      unique case (arg_sel_e'(cmdWrSel))
        ARG_SIZE: argSize <= cmdWrData[SIZE_W-1:0];
        ARG_SRC:  argSrc  <= cmdWrData;
        ARG_DST:  argDst  <= cmdWrData;
        default:  argAck  <= cmdWrData;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wSize <= '0;
      wSrc  <= '0;
      wDst  <= '0;
      wAck  <= '0;
      wType <= PKT_WRITE;
    end else if (ctl.ldCmd) begin
      wSize <= argSize;
      wSrc  <= argSrc;
      wDst  <= argDst;
      wAck  <= argAck;
      wType <= PKT_WRITE;
    end else if (ctl.ldRead) begin
      wSize <= inSize;
      wSrc  <= inSrc;
      wDst  <= inDst;
      wAck  <= inAck;
      wType <= PKT_WRITE;
    end else if (ctl.ldAck) begin
      wSize <= inSize;
      wSrc  <= '0;
      wDst  <= inAck;
      wAck  <= '0;
      wType <= PKT_ACK;
    end else if (ctl.advance) begin
      wSize <= wSize - segSize;
      wSrc  <= wSrc + ADDR_W'(segSize);
      wDst  <= wDst + ADDR_W'(segSize);
    end
  end

  assign outType = wType;
  assign outSize = (wType == PKT_ACK) ? wSize : segSize;
  assign outSrc  = wSrc;
  assign outDst  = wDst;
  assign outAck  = wAck;

endmodule

// File: rtl/rdma_cmd_engine.sv
module rdma_cmd_engine
  import rdma_eng_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 16,
  parameter int MAX_PKT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [1:0]        cmdWrSel,
  input  logic [ADDR_W-1:0] cmdWrData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inType,
  input  logic [SIZE_W-1:0] inSize,
  input  logic [ADDR_W-1:0] inSrc,
  input  logic [ADDR_W-1:0] inDst,
  input  logic [ADDR_W-1:0] inAck,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outType,
  output logic [SIZE_W-1:0] outSize,
  output logic [ADDR_W-1:0] outSrc,
  output logic [ADDR_W-1:0] outDst,
  output logic [ADDR_W-1:0] outAck
);

  eng_ctl_t ctl;
  logic     cmdSizeZero, lastSeg;

  rdma_eng_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .cmdWrSel   (cmdWrSel),
    .inValid    (inValid),
    .inType     (inType),
    .inSizeZero (inSize == '0),
    .cmdSizeZero(cmdSizeZero),
    .lastSeg    (lastSeg),
    .outReady   (outReady),
    .ctl        (ctl),
    .outValid   (outValid),
    .inReady    (inReady)
  );

  rdma_eng_dp #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .MAX_PKT(MAX_PKT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdWrEn    (cmdWrEn),
    .cmdWrSel   (cmdWrSel),
    .cmdWrData  (cmdWrData),
    .inSize     (inSize),
    .inSrc      (inSrc),
    .inDst      (inDst),
    .inAck      (inAck),
    .cmdSizeZero(cmdSizeZero),
    .lastSeg    (lastSeg),
    .outType    (outType),
    .outSize    (outSize),
    .outSrc     (outSrc),
    .outDst     (outDst),
    .outAck     (outAck)
  );

endmodule

// File: rtl/rdma_cmd_engine_chk.sv
module rdma_cmd_engine_chk #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 16,
  parameter int MAX_PKT = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [1:0]        outType,
  input logic [SIZE_W-1:0] outSize,
  input logic [ADDR_W-1:0] outSrc,
  input logic [ADDR_W-1:0] outDst,
  input logic [ADDR_W-1:0] outAck
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outType) && $stable(outSize)
      && $stable(outSrc) && $stable(outDst) && $stable(outAck)); // R9

  AST_SEG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outType == 2'b01 |-> outSize != '0 && outSize <= SIZE_W'(MAX_PKT)); // R3

  AST_NO_READ_OUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outType == 2'b01 || outType == 2'b10); // R5

  AST_BUSY_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R12

endmodule

bind rdma_cmd_engine rdma_cmd_engine_chk #(
  .ADDR_W (ADDR_W),
  .SIZE_W (SIZE_W),
  .MAX_PKT(MAX_PKT)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outType (outType),
  .outSize (outSize),
  .outSrc  (outSrc),
  .outDst  (outDst),
  .outAck  (outAck)
);

// File: tb/rdma_cmd_engine_tb.sv
module rdma_cmd_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cmdWrEn;
  logic [1:0]        cmdWrSel;
  logic [ADDR_W-1:0] cmdWrData;
  logic              inValid;
  logic              inReady;
  logic [1:0]        inType;
  logic [SIZE_W-1:0] inSize;
  logic [ADDR_W-1:0] inSrc, inDst, inAck;
  logic              outValid;
  logic              outReady;
  logic [1:0]        outType;
  logic [SIZE_W-1:0] outSize;
  logic [ADDR_W-1:0] outSrc, outDst, outAck;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdma_cmd_engine u_dut (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrSel(cmdWrSel), .cmdWrData(cmdWrData),
    .inValid(inValid), .inReady(inReady), .inType(inType), .inSize(inSize),
    .inSrc(inSrc), .inDst(inDst), .inAck(inAck),
    .outValid(outValid), .outReady(outReady), .outType(outType), .outSize(outSize),
    .outSrc(outSrc), .outDst(outDst), .outAck(outAck)
  );

  task automatic check(input string tag, input logic ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic writeArg(input logic [1:0] sel, input logic [ADDR_W-1:0] data);
    cmdWrEn = 1'b1; cmdWrSel = sel; cmdWrData = data;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic writeCmd(input int sz, input logic [ADDR_W-1:0] s, d, a);
    writeArg(2'd0, ADDR_W'(sz));
    writeArg(2'd1, s);
    writeArg(2'd2, d);
    writeArg(2'd3, a);
  endtask

  task automatic sendIn(input logic [1:0] t, input int sz, input logic [ADDR_W-1:0] s, d, a);
    inValid = 1'b1; inType = t; inSize = SIZE_W'(sz); inSrc = s; inDst = d; inAck = a;
    for (int w = 0; w < 50 && !inReady; w++) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // waits for a packet, compares all fields, lets it be taken (outReady high)
  task automatic expectPkt(input string tag, input logic [1:0] t, input int sz,
                           input logic [ADDR_W-1:0] s, d, a);
    for (int w = 0; w < 60 && !outValid; w++) @(negedge clk);
    check(tag, outValid && outType == t && outSize == SIZE_W'(sz) && outSrc == s
               && outDst == d && outAck == a,
          $sformatf("v=%0b t=%0d sz=%0d src=%h dst=%h ack=%h", outValid, outType, outSize, outSrc, outDst, outAck),
          $sformatf("v=1 t=%0d sz=%0d src=%h dst=%h ack=%h", t, sz, s, d, a));
    @(negedge clk);
  endtask

  task automatic expectNone(input string tag, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (outValid) seen = 1'b1;
      @(negedge clk);
    end
    check(tag, !seen, $sformatf("packet seen=%0b", seen), "packet seen=0");
  endtask

  task automatic testReset();
    check("R13 reset outValid", outValid == 1'b0, $sformatf("%0b", outValid), "0");
    check("R13 reset inReady", inReady == 1'b1, $sformatf("%0b", inReady), "1");
  endtask

  task automatic testPartialAndOverwrite();
    writeArg(2'd0, 32'd100);
    writeArg(2'd1, 32'h0000_0400);
    writeArg(2'd2, 32'h0000_0600);
    expectNone("R1 three slots only", 6);
    writeArg(2'd0, 32'd30);
    expectNone("R2 rewrite does not launch", 6);
    writeArg(2'd3, 32'h0000_0088);
    expectPkt("R2 latest size used", 2'b01, 30, 32'h400, 32'h600, 32'h88);
    expectNone("R1 single packet only", 4);
  endtask

  task automatic testSegmentation();
    writeCmd(200, 32'h1000, 32'h8000, 32'h3000);
    expectPkt("R3 R4 seg0", 2'b01, 64, 32'h1000, 32'h8000, 32'h3000);
    expectPkt("R3 R4 seg1", 2'b01, 64, 32'h1040, 32'h8040, 32'h3000);
    expectPkt("R3 R4 seg2", 2'b01, 64, 32'h1080, 32'h8080, 32'h3000);
    expectPkt("R3 R5 last remainder", 2'b01, 8, 32'h10C0, 32'h80C0, 32'h3000);
    expectNone("R3 no extra seg", 4);
    writeCmd(128, 32'h2000, 32'h2800, 32'h10);
    expectPkt("R3 exact multiple seg0", 2'b01, 64, 32'h2000, 32'h2800, 32'h10);
    expectPkt("R3 exact multiple seg1", 2'b01, 64, 32'h2040, 32'h2840, 32'h10);
    expectNone("R3 exact multiple no tail", 4);
  endtask

  task automatic testIncoming();
    sendIn(2'b00, 130, 32'h200, 32'h9000, 32'h44);
    expectPkt("R6 read reply 0", 2'b01, 64, 32'h200, 32'h9000, 32'h44);
    expectPkt("R6 read reply 1", 2'b01, 64, 32'h240, 32'h9040, 32'h44);
    expectPkt("R6 read reply 2", 2'b01, 2, 32'h280, 32'h9080, 32'h44);
    expectNone("R6 reply ends", 4);
    sendIn(2'b01, 48, 32'h111, 32'h222, 32'h5550);
    expectPkt("R7 ack for write", 2'b10, 48, 32'h0, 32'h5550, 32'h0);
    expectNone("R7 one ack only", 4);
    sendIn(2'b10, 48, 32'h111, 32'h222, 32'h333);
    expectNone("R8 ack absorbed", 8);
    check("R8 ready after ack", inReady == 1'b1, $sformatf("%0b", inReady), "1");
    sendIn(2'b00, 0, 32'h200, 32'h9000, 32'h44);
    expectNone("R11 zero read", 6);
  endtask

  task automatic testZeroCmd();
    writeCmd(0, 32'h10, 32'h20, 32'h30);
    expectNone("R11 zero command", 8);
    check("R10 mask cleared ready", inReady == 1'b1, $sformatf("%0b", inReady), "1");
    writeArg(2'd1, 32'h10);
    expectNone("R10 fresh slots needed", 6);
    writeArg(2'd0, 32'd5);
    writeArg(2'd2, 32'h20);
    writeArg(2'd3, 32'h30);
    expectPkt("R10 relaunch after refill", 2'b01, 5, 32'h10, 32'h20, 32'h30);
  endtask

  task automatic testStallAndBusyWrites();
    logic held = 1'b1;
    outReady = 1'b0;
    writeCmd(70, 32'h100, 32'h700, 32'h70);
    for (int w = 0; w < 20 && !outValid; w++) @(negedge clk);
    writeCmd(16, 32'hA00, 32'hB00, 32'hC0);
    inValid = 1'b1; inType = 2'b01; inSize = 16'd4; inAck = 32'h9;
    check("R12 busy blocks input", inReady == 1'b0, $sformatf("%0b", inReady), "0");
    inValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (!(outValid && outSize == 16'd64 && outSrc == 32'h100 && outDst == 32'h700)) held = 1'b0;
      @(negedge clk);
    end
    check("R9 held while stalled", held, $sformatf("held=%0b", held), "held=1");
    outReady = 1'b1;
    expectPkt("R9 first seg after stall", 2'b01, 64, 32'h100, 32'h700, 32'h70);
    expectPkt("R4 second seg", 2'b01, 6, 32'h140, 32'h740, 32'h70);
    expectPkt("R10 busy-written command", 2'b01, 16, 32'hA00, 32'hB00, 32'hC0);
    expectNone("R10 nothing after", 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cmdWrEn = 1'b0; cmdWrSel = '0; cmdWrData = '0;
    inValid = 1'b0; inType = '0; inSize = '0; inSrc = '0; inDst = '0; inAck = '0;
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPartialAndOverwrite();
    testSegmentation();
    testIncoming();
    testZeroCmd();
    testStallAndBusyWrites();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule